// File: doc/BRIEF.md
# Timer Trigger Output Selector

This block is the master-side event logic of a small general-purpose timer. An up-counter runs from zero to a programmable reload value and then wraps. Each wrap, and each software update request, raises a one-cycle update strobe. Four compare channels each produce a PWM-style reference level and a one-cycle match strobe. Channel 1 can instead act as a capture channel. Its input is either the first input pin or the XOR of three pins, which suits hall-effect rotor sensors.

A 3-bit mode field chooses which internal signal drives the single registered trigger output. The choices are the software update request, the gated count enable, the update strobe, a channel-1 event pulse, or one of the four reference levels. A second timer can use this output as a start signal, a gate or a prescaled clock. A selection bit decides when the per-channel DMA requests fire. They follow either each channel's own event or the shared update strobe.

Top module: `tmr_master`

## Requirements
- R1: When `cen` is 1 and either `gate_mode` is 0 or `trig_in` is 1, each clock edge advances `cnt` by one. When `cnt` equals `arr` at that edge, it loads 0 instead and `upd_evt` is 1 for the following cycle. Otherwise the count holds.
- R2: A `ug` pulse at an edge loads `cnt` with 0 and sets `upd_evt` to 1 for the next cycle, whatever the enable is.
- R3: `oc_ref[i]` is 1 exactly while `cnt` is below channel i's compare value, held in bits `i*CNT_W +: CNT_W` of `cmp_val`.
- R4: A channel event lasts one cycle. For channel i, it is the first cycle in which `cnt` equals its compare value after `cnt` was advanced or cleared. When `cap1_en` is 1, channel 1's event is instead the cycle after a rising edge of `ti1_out` is seen through two register stages. That event also copies `cnt` into `cap1_val`. With `dma_on_upd` at 0, `dma_req[i]` equals channel i's event.
- R5: With `dma_on_upd` at 1, every bit of `dma_req` equals `upd_evt`.
- R6: `ti1_out` equals `ti_pins[0]` when `ti_sel` is 0. It equals the XOR of `ti_pins[2:0]` when `ti_sel` is 1.
- R7: With `mms` = 0, `trgo` repeats `ug` one cycle later.
- R8: With `mms` = 1, `trgo` repeats the count enable of R1 one cycle later.
- R9: With `mms` = 2, `trgo` repeats `upd_evt` one cycle later.
- R10: With `mms` = 3, `trgo` is 1 in the cycle after every channel-1 event. This holds even when events come on consecutive cycles.
- R11: With `mms` = 4, 5, 6 and 7, `trgo` repeats `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]` respectively, one cycle later.
- R12: While `rst_n` is 0 and in the first cycle after it, the following outputs are 0: `cnt`, `upd_evt`, `trgo`, `dma_req` and `cap1_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen | input | 1 | Counter enable control bit |
| gate_mode | input | 1 | 1: count only while trig_in is high |
| trig_in | input | 1 | Gate input from a slave controller |
| ug | input | 1 | Software update request strobe |
| arr | input | CNT_W | Reload (top) value |
| cmp_val | input | NCH*CNT_W | Packed compare values, channel i at i*CNT_W |
| mms | input | 3 | Trigger output source select |
| dma_on_upd | input | 1 | 0: DMA on channel event, 1: DMA on update |
| ti_sel | input | 1 | 0: ti_pins[0], 1: XOR of three pins |
| ti_pins | input | TI_N | Capture input pins |
| cap1_en | input | 1 | Channel 1 works as capture |
| cnt | output | CNT_W | Counter value |
| upd_evt | output | 1 | Update strobe |
| oc_ref | output | NCH | Compare reference levels |
| dma_req | output | NCH | Per-channel DMA request strobes |
| trgo | output | 1 | Registered trigger output |
| ti1_out | output | 1 | Selected channel-1 input |
| cap1_val | output | CNT_W | Last captured count |

## Verification
The counter, the update strobe and the capture register change on the edge that samples their cause. They are therefore checked one cycle after an input is applied. The reference levels, the channel strobes, the DMA requests and `ti1_out` follow from present state and inputs within the same cycle. `trgo` adds one register, so its expected value is the selected source of the previous cycle. The bench holds these latencies in a reference model that it advances at each rising edge. It applies inputs at the falling edge and compares all outputs two nanoseconds before the next rising edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [2:0] {
      TRG_SWUPD   = 3'd0,
      TRG_RUN     = 3'd1,
      TRG_UPDATE  = 3'd2,
      TRG_CH1EVT  = 3'd3,
      TRG_REF1    = 3'd4,
      TRG_REF2    = 3'd5,
      TRG_REF3    = 3'd6,
      TRG_REF4    = 3'd7
   } trg_mode_e;

   localparam int unsigned TRG_SRC_CH = 4;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cen,
   input  logic             gate_mode,
   input  logic             trig_in,
   input  logic             ug,
   input  logic [CNT_W-1:0] arr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run,
   output logic             upd_q,
   output logic             moved_q
);
   logic wrap;

   if (CNT_W < 2) begin : g_bad_w
      $error("tmr_count: CNT_W must be at least 2");
   end

   always_comb begin
      run  = cen & (gate_mode ? trig_in : 1'b1);
      wrap = run & (cnt_q == arr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         upd_q   <= 1'b0;
         moved_q <= 1'b0;
      end else begin
         upd_q   <= ug | wrap;
         moved_q <= ug | run;
         if (ug || wrap) begin
            cnt_q <= '0;
         end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned NCH   = 4
) (
   input  logic [CNT_W-1:0]     cnt,
   input  logic                 moved,
   input  logic [NCH*CNT_W-1:0] cmp_val,
   output logic [NCH-1:0]       oc_ref,
   output logic [NCH-1:0]       cmp_evt
);
   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [CNT_W-1:0] thr;
      assign thr        = cmp_val[i*CNT_W +: CNT_W];
      assign oc_ref[i]  = (cnt < thr);
      assign cmp_evt[i] = moved & (cnt == thr);
   end
endmodule

// File: rtl/tmr_capin.sv
module tmr_capin #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned TI_N  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ti_sel,
   input  logic [TI_N-1:0]  ti_pins,
   input  logic             cap_en,
   input  logic [CNT_W-1:0] cnt,
   output logic             ti1,
   output logic             cap_evt,
   output logic [CNT_W-1:0] cap_val
);
   logic s1, s2;

   if (TI_N < 1) begin : g_bad_n
      $error("tmr_capin: TI_N must be at least 1");
   end

   if (TI_N == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ti_sel;
      assign ti1 = ti_pins[0];
   end else begin : g_xor
      assign ti1 = ti_sel ? (^ti_pins) : ti_pins[0];
   end

   assign cap_evt = s1 & ~s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1      <= 1'b0;
         s2      <= 1'b0;
         cap_val <= '0;
      end else begin
         s1 <= ti1;
         s2 <= s1;
         if (cap_en && cap_evt) begin
            cap_val <= cnt;
         end
      end
   end
endmodule

// File: rtl/tmr_trgsel.sv
module tmr_trgsel
   import tmr_pkg::*;
#(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     mms,
   input  logic           ug,
   input  logic           run,
   input  logic           upd,
   input  logic           dma_on_upd,
   input  logic [NCH-1:0] ch_evt,
   input  logic [NCH-1:0] oc_ref,
   output logic           trgo_q,
   output logic [NCH-1:0] dma_req
);
   trg_mode_e mode;
   logic      src;

   assign mode = trg_mode_e'(mms);

   always_comb begin
      unique case (mode)
         TRG_SWUPD:  src = ug;
         TRG_RUN:    src = run;
         TRG_UPDATE: src = upd;
         TRG_CH1EVT: src = ch_evt[0];
         TRG_REF1:   src = oc_ref[0];
         TRG_REF2:   src = oc_ref[1];
         TRG_REF3:   src = oc_ref[2];
         TRG_REF4:   src = oc_ref[3];
         default:    src = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trgo_q <= 1'b0;
      else        trgo_q <= src;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_dma
      assign dma_req[i] = dma_on_upd ? upd : ch_evt[i];
   end
endmodule

// File: rtl/tmr_master.sv
module tmr_master
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned NCH   = 4,
   parameter int unsigned TI_N  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cen,
   input  logic                 gate_mode,
   input  logic                 trig_in,
   input  logic                 ug,
   input  logic [CNT_W-1:0]     arr,
   input  logic [NCH*CNT_W-1:0] cmp_val,
   input  logic [2:0]           mms,
   input  logic                 dma_on_upd,
   input  logic                 ti_sel,
   input  logic [TI_N-1:0]      ti_pins,
   input  logic                 cap1_en,
   output logic [CNT_W-1:0]     cnt,
   output logic                 upd_evt,
   output logic [NCH-1:0]       oc_ref,
   output logic [NCH-1:0]       dma_req,
   output logic                 trgo,
   output logic                 ti1_out,
   output logic [CNT_W-1:0]     cap1_val
);
   localparam int unsigned TRG_CH = TRG_SRC_CH;

   logic           run, moved, cap_evt;
   logic [NCH-1:0] cmp_evt, ch_evt;

   if (NCH != TRG_CH) begin : g_bad_nch
      $error("tmr_master: NCH must equal the trigger source channel count");
   end

   tmr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .cen(cen), .gate_mode(gate_mode),
      .trig_in(trig_in), .ug(ug), .arr(arr),
      .cnt_q(cnt), .run(run), .upd_q(upd_evt), .moved_q(moved)
   );

   tmr_cmp #(.CNT_W(CNT_W), .NCH(NCH)) u_cmp (
      .cnt(cnt), .moved(moved), .cmp_val(cmp_val),
      .oc_ref(oc_ref), .cmp_evt(cmp_evt)
   );

   tmr_capin #(.CNT_W(CNT_W), .TI_N(TI_N)) u_capin (
      .clk(clk), .rst_n(rst_n), .ti_sel(ti_sel), .ti_pins(ti_pins),
      .cap_en(cap1_en), .cnt(cnt),
      .ti1(ti1_out), .cap_evt(cap_evt), .cap_val(cap1_val)
   );

   always_comb begin
      ch_evt    = cmp_evt;
      ch_evt[0] = cap1_en ? cap_evt : cmp_evt[0];
   end

   tmr_trgsel #(.NCH(NCH)) u_trgsel (
      .clk(clk), .rst_n(rst_n), .mms(mms), .ug(ug), .run(run),
      .upd(upd_evt), .dma_on_upd(dma_on_upd), .ch_evt(ch_evt),
      .oc_ref(oc_ref), .trgo_q(trgo), .dma_req(dma_req)
   );
endmodule

// File: rtl/tmr_master_chk.sv
module tmr_master_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned NCH   = 4,
   parameter int unsigned TI_N  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ug,
   input logic [NCH*CNT_W-1:0] cmp_val,
   input logic [2:0]           mms,
   input logic                 dma_on_upd,
   input logic                 ti_sel,
   input logic [TI_N-1:0]      ti_pins,
   input logic [CNT_W-1:0]     cnt,
   input logic                 upd_evt,
   input logic [NCH-1:0]       oc_ref,
   input logic [NCH-1:0]       dma_req,
   input logic                 trgo,
   input logic                 ti1_out
);
   p_upd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      upd_evt |-> (cnt == '0));

   p_ug_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ug |=> (upd_evt && cnt == '0));

   for (genvar i = 0; i < NCH; i++) begin : g_ref
      p_ref_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cmp_val[i*CNT_W +: CNT_W] == '0) |-> !oc_ref[i]);
      p_ref_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == '0 && cmp_val[i*CNT_W +: CNT_W] != '0) |-> oc_ref[i]);
   end

   p_dma_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_on_upd |-> (dma_req == {NCH{upd_evt}}));

   p_ti_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ti_sel |-> (ti1_out == ti_pins[0]));

   p_trgo_ug_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mms == 3'd0 && ug) |=> trgo);

   p_trgo_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mms == 3'd2 && upd_evt) |=> trgo);
endmodule

bind tmr_master tmr_master_chk #(.CNT_W(CNT_W), .NCH(NCH), .TI_N(TI_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .ug(ug), .cmp_val(cmp_val), .mms(mms),
   .dma_on_upd(dma_on_upd), .ti_sel(ti_sel), .ti_pins(ti_pins), .cnt(cnt),
   .upd_evt(upd_evt), .oc_ref(oc_ref), .dma_req(dma_req), .trgo(trgo),
   .ti1_out(ti1_out)
);

// File: tb/tmr_master_test.sv
module tmr_master_test;
   localparam int W = 16;
   localparam int N = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cen = 0, gate_mode = 0, trig_in = 0, ug = 0;
   logic [W-1:0]     arr = '0;
   logic [N*W-1:0]   cmp_val = '0;
   logic [2:0]       mms = '0;
   logic             dma_on_upd = 0, ti_sel = 0, cap1_en = 0;
   logic [2:0]       ti_pins = '0;
   logic [W-1:0]     cnt, cap1_val;
   logic             upd_evt, trgo, ti1_out;
   logic [N-1:0]     oc_ref, dma_req;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model state
   logic [W-1:0] m_cnt = '0, m_cap = '0;
   logic         m_upd = 0, m_moved = 0, m_s1 = 0, m_s2 = 0, m_trgo = 0;
   string        m_ttag = "R12";

   always #10 clk = ~clk;

   tmr_master #(.CNT_W(W), .NCH(N), .TI_N(3)) uut (
      .clk(clk), .rst_n(rst_n), .cen(cen), .gate_mode(gate_mode),
      .trig_in(trig_in), .ug(ug), .arr(arr), .cmp_val(cmp_val), .mms(mms),
      .dma_on_upd(dma_on_upd), .ti_sel(ti_sel), .ti_pins(ti_pins),
      .cap1_en(cap1_en), .cnt(cnt), .upd_evt(upd_evt), .oc_ref(oc_ref),
      .dma_req(dma_req), .trgo(trgo), .ti1_out(ti1_out), .cap1_val(cap1_val)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] thr(input int i);
      return cmp_val[i*W +: W];
   endfunction

   function automatic logic model_ti();
      return ti_sel ? ^ti_pins : ti_pins[0];
   endfunction

   // one clock: check present outputs before the edge, then advance model
   task automatic step();
      logic [N-1:0] e_ref, e_evt, e_dma;
      logic         e_run, e_cap, e_src, e_wrap;
      #8;
      e_run = cen & (gate_mode ? trig_in : 1'b1);
      e_cap = m_s1 & ~m_s2;
      for (int i = 0; i < N; i++) begin
         e_ref[i] = (m_cnt < thr(i));
         e_evt[i] = m_moved & (m_cnt == thr(i));
      end
      if (cap1_en) e_evt[0] = e_cap;
      e_dma = dma_on_upd ? {N{m_upd}} : e_evt;
      chk("R1 cnt", 32'(cnt), 32'(m_cnt));
      chk("R1 upd_evt", 32'(upd_evt), 32'(m_upd));
      chk("R3 oc_ref", 32'(oc_ref), 32'(e_ref));
      chk(dma_on_upd ? "R5 dma_req" : "R4 dma_req", 32'(dma_req), 32'(e_dma));
      chk("R6 ti1_out", 32'(ti1_out), 32'(model_ti()));
      chk("R4 cap1_val", 32'(cap1_val), 32'(m_cap));
      chk({m_ttag, " trgo"}, 32'(trgo), 32'(m_trgo));
      case (mms)
         3'd0: begin e_src = ug;        m_ttag = "R7";  end
         3'd1: begin e_src = e_run;     m_ttag = "R8";  end
         3'd2: begin e_src = m_upd;     m_ttag = "R9";  end
         3'd3: begin e_src = e_evt[0];  m_ttag = "R10"; end
         default: begin e_src = e_ref[mms - 3'd4]; m_ttag = "R11"; end
      endcase
      @(posedge clk);
      e_wrap  = e_run & (m_cnt == arr);
      m_trgo  = e_src;
      if (cap1_en && e_cap) m_cap = m_cnt;
      m_upd   = ug | e_wrap;
      m_moved = ug | e_run;
      if (ug || e_wrap) m_cnt = '0;
      else if (e_run)  m_cnt = m_cnt + 1'b1;
      m_s2 = m_s1;
      m_s1 = model_ti();
      @(negedge clk);
   endtask

   task automatic rand_cfg(input int seg);
      mms        = 3'(seg % 8);
      dma_on_upd = $urandom % 2;
      ti_sel     = $urandom % 2;
      gate_mode  = ($urandom % 4) == 0;
      cap1_en    = ($urandom % 3) == 0;
      arr        = W'($urandom % 12);
      for (int i = 0; i < N; i++) cmp_val[i*W +: W] = W'($urandom % 14);
   endtask

   initial begin
      void'($urandom(32'd2024));
      // R12: reset state
      repeat (3) @(negedge clk);
      chk("R12 cnt", 32'(cnt), 0);
      chk("R12 upd_evt", 32'(upd_evt), 0);
      chk("R12 trgo", 32'(trgo), 0);
      chk("R12 dma_req", 32'(dma_req), 0);
      chk("R12 cap1_val", 32'(cap1_val), 0);
      rst_n = 1'b1;

      // R1: reload of zero gives an update every enabled cycle
      cen = 1; arr = '0; mms = 3'd2;
      repeat (6) step();
      // R10: channel-1 events on consecutive cycles keep trgo high
      mms = 3'd3; cmp_val = '0;
      repeat (6) step();
      // R2: software update mid-count, ug routed to trgo (R7)
      arr = W'(9); mms = 3'd0; cmp_val = {W'(7), W'(5), W'(3), W'(1)};
      repeat (4) step();
      ug = 1; step(); ug = 0;
      repeat (3) step();
      // R8: gate input controls count enable
      mms = 3'd1; gate_mode = 1;
      for (int k = 0; k < 12; k++) begin trig_in = k[1]; step(); end
      gate_mode = 0;
      // R6 / R4: XOR capture source with capture enabled
      cap1_en = 1; ti_sel = 1; mms = 3'd3;
      for (int k = 0; k < 16; k++) begin ti_pins = 3'(k / 2); step(); end
      cap1_en = 0;

      // constrained random segments cover every trigger mode
      for (int seg = 0; seg < 24; seg++) begin
         rand_cfg(seg);
         ug = 1; step(); ug = 0;
         for (int c = 0; c < 120; c++) begin
            cen     = ($urandom % 10) != 0;
            trig_in = $urandom % 2;
            ug      = ($urandom % 25) == 0;
            if (c % 3 == 0) ti_pins = 3'($urandom);
            step();
         end
         ug = 0;
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #4_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule